// File: doc/BRIEF.md
# Hardwired Stage Timing Sequencer

This block generates the time-step enables for a hardwired control unit. A small binary step counter advances once per clock, and a decoder turns the count into a one-hot set of step enables T0 to T7. Control equations elsewhere AND these enables with opcode decodes, so each control signal fires only in its intended step. The first six steps carry the instruction phases in this order: fetch, decode, evaluate address, fetch operands, execute, store.

Instructions that need fewer than eight steps raise `finish_i` in their last step, and the following cycle starts again at T0 for the next instruction. A `stall_i` input freezes the step, for example while a memory access has not yet completed. Reset is synchronous and puts the sequencer at T0.

Top module: `stage_timing_sequencer`

## Requirements
- R1: When `rst` is high at a rising clock edge, the next count is 0 and `step_onehot_o` equals 8'b0000_0001 (only T0, bit 0, set).
- R2: `step_onehot_o` always has exactly one bit set, and that bit's index equals `step_count_o` (bit k is Tk).
- R3: With `rst`, `stall_i` and `finish_i` all low at a rising edge, the count increases by exactly one.
- R4: With no stall and no finish, step 7 is followed by step 0 (the count wraps).
- R5: With `finish_i` high and `stall_i` low at a rising edge, the next step is T0 (count 0), whatever the current step.
- R6: With `stall_i` high at a rising edge (and `rst` low), the count and enables hold their value; `stall_i` takes priority over `finish_i`, so a finish presented during a stall has no effect.
- R7: From reset with no stall and no finish, the six phase steps fetch, decode, evaluate address, fetch operands, execute, store appear on T0, T1, T2, T3, T4, T5 in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| finish_i | input | 1 | Current instruction ends in this step; restart at T0 |
| stall_i | input | 1 | Hold the current step |
| step_onehot_o | output | 8 | One-hot step enables, bit k is Tk |
| step_count_o | output | 3 | Binary step number |

## Verification
Every input is sampled at a rising edge and its effect is visible on both outputs right after that same edge, one cycle of latency, since the decoder is combinational behind the count register. The bench changes `stall_i`, `finish_i` and `rst` only at falling edges and reads the outputs 1 ns after the following rising edge, so each comparison sees exactly the cycle the requirement refers to. The expected step is kept in a bench variable updated with the requirement rules (stall first, then finish, else add one modulo eight), and the expected enables are formed by shifting a single one left by that step.

// File: rtl/tss_pkg.sv
package tss_pkg;

  localparam int unsigned DEF_CNT_W = 3;

  // Phase names carried by the first six steps.
  typedef enum logic [2:0] {
    PH_FETCH    = 3'd0,
    PH_DECODE   = 3'd1,
    PH_EVAL_ADR = 3'd2,
    PH_OPERANDS = 3'd3,
    PH_EXECUTE  = 3'd4,
    PH_STORE    = 3'd5
  } phase_e;

  // Next step value; stall outranks finish, finish outranks advance.
  function automatic logic [DEF_CNT_W-1:0] next_step(
    input logic [DEF_CNT_W-1:0] cur,
    input logic                 stall,
    input logic                 finish
  );
    logic [DEF_CNT_W-1:0] nxt;
    if (stall)       nxt = cur;
    else if (finish) nxt = '0;
    else             nxt = cur + 1'b1;
    return nxt;
  endfunction

endpackage

// File: rtl/tss_step_counter.sv
module tss_step_counter #(
  parameter int unsigned CNT_W = tss_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stall,
  input  logic             finish,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= tss_pkg::next_step(count_q, stall, finish);
  end

  assign count = count_q;
endmodule

// File: rtl/tss_step_decoder.sv
module tss_step_decoder #(
  parameter int unsigned CNT_W = tss_pkg::DEF_CNT_W,
  localparam int unsigned N_STEPS = 1 << CNT_W
) (
  input  logic [CNT_W-1:0]   count,
  output logic [N_STEPS-1:0] onehot
);
  for (genvar k = 0; k < N_STEPS; k++) begin : g_step
    assign onehot[k] = (count == CNT_W'(k));
  end
endmodule

// File: rtl/stage_timing_sequencer.sv
module stage_timing_sequencer #(
  parameter int unsigned CNT_W = tss_pkg::DEF_CNT_W,
  localparam int unsigned N_STEPS = 1 << CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               finish_i,
  input  logic               stall_i,
  output logic [N_STEPS-1:0] step_onehot_o,
  output logic [CNT_W-1:0]   step_count_o
);
  // Named events for the checker.
  logic adv_ev;
  logic restart_ev;
  logic hold_ev;

  assign hold_ev    = stall_i;
  assign restart_ev = finish_i & ~stall_i;
  assign adv_ev     = ~finish_i & ~stall_i;

  logic [CNT_W-1:0] count_w;

  tss_step_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .stall  (stall_i),
    .finish (finish_i),
    .count  (count_w)
  );

  tss_step_decoder #(.CNT_W(CNT_W)) u_dec (
    .count  (count_w),
    .onehot (step_onehot_o)
  );

  assign step_count_o = count_w;
endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
  parameter int unsigned CNT_W = 3,
  localparam int unsigned N_STEPS = 1 << CNT_W
) (
  input logic               clk,
  input logic               rst,
  input logic               adv_ev,
  input logic               restart_ev,
  input logic               hold_ev,
  input logic [N_STEPS-1:0] step_onehot_o,
  input logic [CNT_W-1:0]   step_count_o
);
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (step_count_o == '0) && (step_onehot_o == N_STEPS'(1)));

  p_onehot_match_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_onehot_o) && step_onehot_o[step_count_o]);

  p_advance_r3: assert property (@(posedge clk) disable iff (rst)
    adv_ev |=> step_count_o == CNT_W'($past(step_count_o) + 1'b1));

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (adv_ev && step_onehot_o[N_STEPS-1]) |=> step_onehot_o[0]);

  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    restart_ev |=> step_count_o == '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    hold_ev |=> $stable(step_count_o) && $stable(step_onehot_o));
endmodule

bind stage_timing_sequencer tss_checker #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .adv_ev        (adv_ev),
  .restart_ev    (restart_ev),
  .hold_ev       (hold_ev),
  .step_onehot_o (step_onehot_o),
  .step_count_o  (step_count_o)
);

// File: tb/test_stage_timing_sequencer.sv
`timescale 1ns/1ps
module test_stage_timing_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       finish_i = 1'b0;
  logic       stall_i = 1'b0;
  logic [7:0] step_onehot_o;
  logic [2:0] step_count_o;

  int n_checks = 0;
  int n_errors = 0;
  int exp_step = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  stage_timing_sequencer i_stage_timing_sequencer (
    .clk           (clk),
    .rst           (rst),
    .finish_i      (finish_i),
    .stall_i       (stall_i),
    .step_onehot_o (step_onehot_o),
    .step_count_o  (step_count_o)
  );

  task automatic check(input string req);
    logic [7:0] exp_oh;
    exp_oh = 8'b1 << exp_step;
    n_checks++;
    if (step_count_o !== 3'(exp_step) || step_onehot_o !== exp_oh) begin
      n_errors++;
      $display("FAIL %s: count=%0d onehot=%b expected count=%0d onehot=%b",
               req, step_count_o, step_onehot_o, exp_step, exp_oh);
    end
  endtask

  // One clock with given controls; bench model updates expected step.
  task automatic cycle(input bit r, input bit s, input bit f);
    @(negedge clk);
    rst = r; stall_i = s; finish_i = f;
    @(posedge clk);
    #1;
    if (r)      exp_step = 0;
    else if (s) exp_step = exp_step;
    else if (f) exp_step = 0;
    else        exp_step = (exp_step + 1) % 8;
  endtask

  task automatic t_reset;
    cycle(1, 0, 0); cycle(1, 0, 1);
    check("R1 reset state");
  endtask

  task automatic t_phase_order;
    cycle(1, 0, 0);
    check("R7 fetch on T0");
    for (int k = 1; k < 6; k++) begin
      cycle(0, 0, 0);
      check("R7 phase order");
    end
  endtask

  task automatic t_count_and_wrap;
    cycle(1, 0, 0);
    for (int k = 0; k < 7; k++) begin
      cycle(0, 0, 0);
      check("R3 advance");
    end
    cycle(0, 0, 0);
    check("R4 wrap 7 to 0");
    cycle(0, 0, 0);
    check("R2 onehot after wrap");
  endtask

  task automatic t_finish_early;
    int stops[4] = '{0, 2, 5, 7};
    foreach (stops[i]) begin
      cycle(1, 0, 0);
      for (int k = 0; k < stops[i]; k++) cycle(0, 0, 0);
      check("R2 step before finish");
      cycle(0, 0, 1);
      check("R5 finish restarts at T0");
      cycle(0, 0, 0);
      check("R3 advance after restart");
    end
  endtask

  task automatic t_stall;
    cycle(1, 0, 0);
    cycle(0, 0, 0); cycle(0, 0, 0); cycle(0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      cycle(0, 1, 0);
      check("R6 stall holds");
    end
    cycle(0, 1, 1);
    check("R6 finish ignored while stalled");
    cycle(0, 0, 0);
    check("R3 advance after stall");
  endtask

  task automatic t_reset_mid;
    cycle(0, 0, 0); cycle(0, 1, 0);
    cycle(1, 1, 0);
    check("R1 reset overrides stall");
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_phase_order();
    t_count_and_wrap();
    t_finish_early();
    t_stall();
    t_reset_mid();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule